// File: doc/BRIEF.md
# Program and Erase Strobe Controller

This block runs on the programmer side of a link to a block-organised nonvolatile device. It drives the device's active-low program/erase strobe. Once the data shift and the address setup for a block are finished, the sequencer asks for one of two operations. A block-program request programs the block that is currently addressed. A bulk-erase request clears the whole array. The controller then holds the strobe low for a time measured in milliseconds and releases it. It reports that it is busy for the whole operation and gives a one-cycle completion flag.

The pulse length comes from two lookup tables, one for erase and one for program. Each table has eight entries and takes a 3-bit timing code that the caller has already decoded from the device's identification bytes. A millisecond prescaler divides the system clock by the parameter `CLKS_PER_MS`. The prescaler restarts at the first cycle of every pulse, so a pulse of N ms lasts exactly N × `CLKS_PER_MS` clock cycles. The controller keeps the strobe high whenever the programming voltage is present and no pulse is running. It ends a pulse early if that voltage goes away.

The FSM has four states. IDLE leaves for ARM on an accepted request (ACCEPT). ARM goes to PULSE on the next edge (FIRE), or returns to IDLE if the voltage is gone (ABORT). PULSE goes to FINISH when the timer expires (EXPIRE), or returns to IDLE on loss of voltage (ABORT). FINISH always returns to IDLE (RELEASE).

Top module: `pep_pulse_ctrl`

## Requirements
- R1: After reset, strobe_n is 1 and busy and done are 0.
- R2: Whenever hv_on is sampled low at a clock edge, strobe_n is 1 in the following cycle. Outside a running pulse, strobe_n is always 1.
- R3: A request is accepted only in IDLE, with hv_on and setup_done both high at the sampling edge. A request without setup_done or without hv_on leaves busy at 0 and strobe_n at 1.
- R4: After a request is accepted at edge E0, busy is high and strobe_n high during the next cycle (ARM). strobe_n goes low at edge E0+1 and stays low for exactly ms × CLKS_PER_MS cycles.
- R5: An erase request (req_erase) uses the erase table, with codes 0 to 5 giving 100, 150, 200, 250, 300 and 400 ms.
- R6: A program request (req_prog) uses the program table, with codes 0 to 5 giving 20, 30, 50, 75, 100 and 150 ms.
- R7: Unused codes 6 and 7 give a default of 500 ms for erase and 200 ms for program.
- R8: When req_erase and req_prog are both high in the accepting cycle, the erase operation is performed.
- R9: Any request that arrives while busy is high is ignored, including one in the done cycle. The running pulse keeps its length, and busy falls in the cycle after done.
- R10: done is high for exactly one cycle, which is the first cycle with strobe_n back high after a complete pulse.
- R11: If hv_on is low while in ARM or PULSE, the operation ends: strobe_n is 1 and busy is 0 in the next cycle, and done is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_on | input | 1 | Programming voltage is applied |
| setup_done | input | 1 | Data shift and address setup have completed |
| req_prog | input | 1 | Request a block-program pulse |
| req_erase | input | 1 | Request a bulk-erase pulse |
| erase_code | input | 3 | Decoded bulk-erase timing code |
| prog_code | input | 3 | Decoded block-program timing code |
| strobe_n | output | 1 | Active-low program/erase strobe to the device |
| busy | output | 1 | Operation in progress (ARM, PULSE, FINISH) |
| done | output | 1 | One-cycle flag when a complete pulse ends |

## Verification
The two events that can meet in one cycle are a new request and the completion of the current pulse. The bench raises req_prog exactly in the cycle where it sees done high. It then checks that busy falls on the next cycle and stays low, and that no second pulse starts. The same collision is tried against an abort: hv_on is dropped in the middle of a pulse, and the bench checks that the strobe goes high on the next cycle with no done flag. A request placed in ARM and another in the middle of a pulse are judged by the measured low time, which must still match the original request's table entry.

// File: rtl/pep_pkg.sv
package pep_pkg;

    localparam int CODE_W = 3;
    localparam int MS_W   = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_PULSE  = 2'd2,
        ST_FINISH = 2'd3
    } pep_state_e;

    // Bulk-erase durations in ms; unused codes fall back to the longest safe time
    function automatic logic [MS_W-1:0] erase_ms(input logic [CODE_W-1:0] code);
        logic [MS_W-1:0] v;
        case (code)
            3'd0:    v = MS_W'(100);
            3'd1:    v = MS_W'(150);
            3'd2:    v = MS_W'(200);
            3'd3:    v = MS_W'(250);
            3'd4:    v = MS_W'(300);
            3'd5:    v = MS_W'(400);
            default: v = MS_W'(500);
        endcase
        return v;
    endfunction

    // Block-program durations in ms
    function automatic logic [MS_W-1:0] prog_ms(input logic [CODE_W-1:0] code);
        logic [MS_W-1:0] v;
        case (code)
            3'd0:    v = MS_W'(20);
            3'd1:    v = MS_W'(30);
            3'd2:    v = MS_W'(50);
            3'd3:    v = MS_W'(75);
            3'd4:    v = MS_W'(100);
            3'd5:    v = MS_W'(150);
            default: v = MS_W'(200);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pep_time_lut.sv
module pep_time_lut
    import pep_pkg::*;
(
    input  logic              sel_erase,
    input  logic [CODE_W-1:0] erase_code,
    input  logic [CODE_W-1:0] prog_code,
    output logic [MS_W-1:0]   pulse_ms
);

    localparam int DEPTH = 1 << CODE_W;

    logic [MS_W-1:0] erase_tab [DEPTH];
    logic [MS_W-1:0] prog_tab  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        assign erase_tab[g] = erase_ms(CODE_W'(g));
        assign prog_tab[g]  = prog_ms(CODE_W'(g));
    end

    assign pulse_ms = sel_erase ? erase_tab[erase_code] : prog_tab[prog_code];

endmodule

// File: rtl/pep_ms_timer.sv
module pep_ms_timer #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_W        = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    input  logic            run,
    output logic            expire
);

    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0]   pre_q;
    logic [MS_W-1:0] ms_left_q;
    logic            ms_edge;

    assign ms_edge = (pre_q == LAST);
    assign expire  = run && ms_edge && (ms_left_q == MS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            ms_left_q <= '0;
        end else if (load) begin
            pre_q     <= '0;
            ms_left_q <= load_ms;
        end else if (run) begin
            if (ms_edge) begin
                pre_q     <= '0;
                ms_left_q <= ms_left_q - MS_W'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/pep_pulse_ctrl.sv
module pep_pulse_ctrl
    import pep_pkg::*;
#(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_on,
    input  logic              setup_done,
    input  logic              req_prog,
    input  logic              req_erase,
    input  logic [CODE_W-1:0] erase_code,
    input  logic [CODE_W-1:0] prog_code,
    output logic              strobe_n,
    output logic              busy,
    output logic              done
);

    pep_state_e        state_q, state_d;
    logic              accept;
    logic              kind_erase_q;
    logic [CODE_W-1:0] ecode_q, pcode_q;
    logic [MS_W-1:0]   pulse_ms;
    logic              tmr_load, tmr_run, tmr_expire;

    assign accept = (state_q == ST_IDLE) && hv_on && setup_done && (req_prog || req_erase);

    // Operation and codes are captured at acceptance; erase wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_erase_q <= 1'b0;
            ecode_q      <= '0;
            pcode_q      <= '0;
        end else if (accept) begin
            kind_erase_q <= req_erase;
            ecode_q      <= erase_code;
            pcode_q      <= prog_code;
        end
    end

    pep_time_lut u_lut (
        .sel_erase  (kind_erase_q),
        .erase_code (ecode_q),
        .prog_code  (pcode_q),
        .pulse_ms   (pulse_ms)
    );

    pep_ms_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .MS_W        (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ms (pulse_ms),
        .run     (tmr_run),
        .expire  (tmr_expire)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ARM;
            ST_ARM:    state_d = hv_on ? ST_PULSE : ST_IDLE;
            ST_PULSE: begin
                if (!hv_on)          state_d = ST_IDLE;
                else if (tmr_expire) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        strobe_n = 1'b1;
        busy     = 1'b0;
        done     = 1'b0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARM: begin
                busy     = 1'b1;
                tmr_load = 1'b1;
            end
            ST_PULSE: begin
                busy     = 1'b1;
                strobe_n = 1'b0;
                tmr_run  = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pep_pulse_chk.sv
module pep_pulse_chk (
    input logic clk,
    input logic rst_n,
    input logic hv_on,
    input logic setup_done,
    input logic req_prog,
    input logic req_erase,
    input logic strobe_n,
    input logic busy,
    input logic done
);

    // R2
    hv_off_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_on |=> strobe_n);

    // R2
    strobe_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> busy);

    // R3
    start_needs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(hv_on && setup_done && (req_prog || req_erase)));

    // R10
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> strobe_n && $past(!strobe_n));

    // R9
    busy_drops_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_on |=> !done);

endmodule

bind pep_pulse_ctrl pep_pulse_chk u_pep_pulse_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hv_on      (hv_on),
    .setup_done (setup_done),
    .req_prog   (req_prog),
    .req_erase  (req_erase),
    .strobe_n   (strobe_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_pep_pulse_ctrl.sv
module test_pep_pulse_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 2;
    localparam int NVEC       = 19;

    // {erase, prog, ecode[2:0], pcode[2:0], ms[9:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd0, 3'd0, 10'd100},  // R5
        {1'b1, 1'b0, 3'd1, 3'd0, 10'd150},  // R5
        {1'b1, 1'b0, 3'd2, 3'd0, 10'd200},  // R5
        {1'b1, 1'b0, 3'd3, 3'd0, 10'd250},  // R5
        {1'b1, 1'b0, 3'd4, 3'd0, 10'd300},  // R5
        {1'b1, 1'b0, 3'd5, 3'd0, 10'd400},  // R5
        {1'b1, 1'b0, 3'd6, 3'd0, 10'd500},  // R7
        {1'b1, 1'b0, 3'd7, 3'd0, 10'd500},  // R7
        {1'b0, 1'b1, 3'd0, 3'd0, 10'd20},   // R6
        {1'b0, 1'b1, 3'd0, 3'd1, 10'd30},   // R6
        {1'b0, 1'b1, 3'd0, 3'd2, 10'd50},   // R6
        {1'b0, 1'b1, 3'd0, 3'd3, 10'd75},   // R6
        {1'b0, 1'b1, 3'd0, 3'd4, 10'd100},  // R6
        {1'b0, 1'b1, 3'd0, 3'd5, 10'd150},  // R6
        {1'b0, 1'b1, 3'd0, 3'd6, 10'd200},  // R7
        {1'b0, 1'b1, 3'd0, 3'd7, 10'd200},  // R7
        {1'b1, 1'b1, 3'd2, 3'd2, 10'd200},  // R8
        {1'b1, 1'b1, 3'd0, 3'd7, 10'd100},  // R8
        {1'b0, 1'b1, 3'd6, 3'd1, 10'd30}    // R6 erase code ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hv_on = 1'b0;
    logic       setup_done = 1'b0;
    logic       req_prog = 1'b0;
    logic       req_erase = 1'b0;
    logic [2:0] erase_code = 3'd0;
    logic [2:0] prog_code = 3'd0;
    logic       strobe_n, busy, done;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pep_pulse_ctrl #(.CLKS_PER_MS(CPM)) i_pep_pulse_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_on      (hv_on),
        .setup_done (setup_done),
        .req_prog   (req_prog),
        .req_erase  (req_erase),
        .erase_code (erase_code),
        .prog_code  (prog_code),
        .strobe_n   (strobe_n),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // Issue a one-cycle request at a negedge, then check the ARM cycle (R4)
    task automatic start(input bit e, input bit p, input logic [2:0] ec,
                         input logic [2:0] pc, input bit hold_in_arm);
        @(negedge clk);
        erase_code = ec;
        prog_code  = pc;
        req_erase  = e;
        req_prog   = p;
        @(negedge clk);
        chk(busy === 1'b1 && strobe_n === 1'b1, "R4 arm cycle", {busy, strobe_n}, 2'b11);
        req_prog  = 1'b0;
        req_erase = hold_in_arm;   // extra request in ARM (R9)
        erase_code = ~ec;          // later code changes must not matter
        prog_code  = ~pc;
    endtask

    // Follow the pulse until busy falls
    task automatic measure(input int inj_at, input bit inj_done,
                           output int low, output int dn, output int first_low);
        low = 0;
        dn = 0;
        first_low = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            req_erase = (i == inj_at);
            req_prog  = inj_done && done;
            if (strobe_n === 1'b0) begin
                if (first_low < 0) first_low = i;
                low++;
            end
            if (done === 1'b1) dn++;
            if (busy === 1'b0) break;
        end
        req_erase = 1'b0;
        req_prog  = 1'b0;
    endtask

    task automatic idle_check(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(busy === 1'b0 && strobe_n === 1'b1 && done === 1'b0, req,
                {busy, strobe_n, done}, 3'b010);
        end
    endtask

    initial begin
        int low, dn, fl;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(strobe_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset",
            {strobe_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        hv_on = 1'b1;
        setup_done = 1'b1;
        @(negedge clk);
        chk(strobe_n === 1'b1 && busy === 1'b0, "R1 after reset", {strobe_n, busy}, 2'b10);

        // Table walk: R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            start(VEC[v][17], VEC[v][16], VEC[v][15:13], VEC[v][12:10], 1'b0);
            measure(-1, 1'b0, low, dn, fl);
            chk(low == int'(VEC[v][9:0]) * CPM, "R4 pulse length", low, int'(VEC[v][9:0]) * CPM);
            chk(fl == 0, "R4 strobe falls after arm", fl, 0);
            chk(dn == 1, "R10 single done", dn, 1);
        end

        // R3: no setup_done
        setup_done = 1'b0;
        @(negedge clk);
        req_prog = 1'b1;
        @(negedge clk);
        req_prog = 1'b0;
        idle_check("R3 no setup", 3);
        setup_done = 1'b1;

        // R3 R2: no programming voltage
        hv_on = 1'b0;
        @(negedge clk);
        req_erase = 1'b1;
        @(negedge clk);
        req_erase = 1'b0;
        idle_check("R3 no voltage", 3);
        hv_on = 1'b1;

        // R9: request in ARM and mid-pulse, program code 0 = 20 ms
        start(1'b0, 1'b1, 3'd5, 3'd0, 1'b1);
        measure(10, 1'b0, low, dn, fl);
        chk(low == 20 * CPM, "R9 busy request ignored", low, 20 * CPM);
        chk(dn == 1, "R9 one done", dn, 1);

        // R9 R10: request in the done cycle is ignored
        start(1'b0, 1'b1, 3'd0, 3'd1, 1'b0);
        measure(-1, 1'b1, low, dn, fl);
        chk(low == 30 * CPM, "R9 length with done-cycle request", low, 30 * CPM);
        idle_check("R9 done-cycle request", 4);

        // R11: abort mid-pulse
        start(1'b1, 1'b0, 3'd0, 3'd0, 1'b0);
        repeat (10) @(negedge clk);
        chk(strobe_n === 1'b0, "R11 pulse running", strobe_n, 0);
        hv_on = 1'b0;
        @(negedge clk);
        chk(strobe_n === 1'b1 && busy === 1'b0, "R11 abort", {strobe_n, busy}, 2'b10);
        idle_check("R11 no done after abort", 3);

        // R11: abort in ARM
        hv_on = 1'b1;
        @(negedge clk);
        req_prog = 1'b1;
        @(negedge clk);
        req_prog = 1'b0;
        hv_on = 1'b0;
        chk(busy === 1'b1, "R11 in arm", busy, 1);
        idle_check("R11 arm abort", 3);
        hv_on = 1'b1;

        // R2: normal operation after aborts
        start(1'b0, 1'b1, 3'd0, 3'd2, 1'b0);
        measure(-1, 1'b0, low, dn, fl);
        chk(low == 50 * CPM && dn == 1, "R2 recovery pulse", low, 50 * CPM);

        finish_run();
    end

endmodule